// File: doc/BRIEF.md
# Pupil Centroid Column Reducer

This block runs the horizontal pass of a column-parallel pupil tracker. Each column of the sensor array has already counted its dark (pupil) pixels during the row-by-row readout. For each column it also holds two weighted sums: the column index times that count, and the sum of the row indices of those pixels. After a start pulse the block drives a column index onto a shared select line, one column per clock, in ascending order. It adds the three values the selected column returns into three frame-wide accumulators.

When the last column has been added, the block computes the pupil centre. It divides the X-weighted total by the area and then the Y-weighted total by the area. Both divisions share one restoring divider that produces one quotient bit per clock. Each quotient carries `FRAC_BITS` fractional bits, so the centre has sub-pixel precision. A frame with no dark pixels skips the divider. It reports a zero centre and raises a no-pupil flag. A one-cycle done pulse marks the moment the new results appear. The results then stay fixed until the next accepted start.

The whole frame therefore costs NY readout steps in the column array plus NX steps here, plus a short divide tail. With a 640×480 frame at 500 frames per second, the first two terms need about 560 kHz.

Top module: `centroid_reducer`

## Requirements
- R1: An accepted start clears the three accumulators and drives `colSel` to 0 in the next cycle. `colSel` then advances by one each clock up to NX-1, and the value returned while `colSel` = k is the contribution of column k.
- R2: After done, `area` equals the sum of `colArea` over all NX columns of the frame.
- R3: For a nonzero area, `centX` equals floor(ΣcolSumX · 2^FRAC_BITS / area).
- R4: For a nonzero area, `centY` equals floor(ΣcolSumY · 2^FRAC_BITS / area).
- R5: When the area is zero, `noPupil` is 1 and `centX` and `centY` are 0. When the area is nonzero, `noPupil` is 0.
- R6: `done` is high for exactly one cycle. Counting the clock edge that samples start as edge 0, `done` is high after edge NX+3+2·QW for a nonzero area and after edge NX+1 for a zero area. Here QW = max(clog2(NX), clog2(NY)) + FRAC_BITS.
- R7: `area`, `centX`, `centY` and `noPupil` change only at the edge that raises `done`. They hold when the column inputs change afterwards.
- R8: A start pulse while a frame is in progress is ignored. The running frame keeps its latency and its results.
- R9: After reset, `done`, `noPupil`, `area`, `centX`, `centY` and `colSel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame reduction (accepted only when idle) |
| colSel | output | clog2(NX) | Index of the column enabled onto the shared bus |
| colArea | input | clog2(NY+1) | Dark-pixel count of the selected column |
| colSumX | input | clog2(NX)+clog2(NY+1) | Column index times that count |
| colSumY | input | clog2(NY)+clog2(NY+1) | Sum of the row indices of dark pixels in the column |
| area | output | clog2(NX·NY+1) | Total dark-pixel count of the frame |
| centX | output | clog2(NX)+FRAC_BITS | Centre column, fixed point with FRAC_BITS fraction bits |
| centY | output | clog2(NY)+FRAC_BITS | Centre row, fixed point with FRAC_BITS fraction bits |
| noPupil | output | 1 | Frame had no dark pixel |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench places a single dark pixel at every position of a small array. This catches a divider that drops or shifts a fractional bit, and an accumulator that skips the first or last column; either error moves the centre by a visible amount. Empty and full frames cover the zero-area bypass, which a faulty design would feed to the divider, and the largest sums. Random masks of several densities stress the carry and remainder paths. A second start pulse mid-frame would shorten the latency or scramble the sums in a design that restarts. Changing the column data after done would alter the published values in a design that does not latch them.

// File: rtl/centroid_pkg.sv
package centroid_pkg;
  typedef struct packed {
    logic clearAcc;
    logic accum;
    logic loadX;
    logic loadY;
    logic step;
    logic keepX;
    logic publish;
    logic zeroOut;
  } ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_PREP, ST_DIVX, ST_MIDY, ST_DIVY, ST_FIN
  } state_t;
endpackage

// File: rtl/centroid_divider.sv
// Restoring divider: one quotient bit per clock. Requires dividend < divisor * 2^QW.
module centroid_divider #(
  parameter int AREA_W = 8,
  parameter int QW = 8,
  localparam int DV_W = AREA_W + QW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [DV_W-1:0]   dividend,
  input  logic [AREA_W-1:0] divisor,
  output logic [QW-1:0]     quotient
);
  logic [AREA_W-1:0] rem, dvs;
  logic [QW-1:0]     shiftReg;
  logic [AREA_W:0]   trial, diff;
  logic              fits;

  always_comb begin
    trial = {rem, shiftReg[QW-1]};
    diff  = trial - {1'b0, dvs};
    fits  = trial >= {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0;
      dvs <= '0;
      shiftReg <= '0;
    end else if (load) begin
      rem <= dividend[DV_W-1:QW];
      shiftReg <= dividend[QW-1:0];
      dvs <= divisor;
    end else if (step) begin
      rem <= fits ? diff[AREA_W-1:0] : trial[AREA_W-1:0];
      shiftReg <= {shiftReg[QW-2:0], fits};
    end
  end

  assign quotient = shiftReg;
endmodule

// File: rtl/centroid_ctrl.sv
module centroid_ctrl
  import centroid_pkg::*;
#(
  parameter int NX = 640,
  parameter int QW = 16,
  localparam int COL_W = $clog2(NX),
  localparam int CNT_W = $clog2(QW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             areaZero,
  output ctrl_t            ctl,
  output logic [COL_W-1:0] colSel,
  output logic             scanning,
  output logic             done
);
  state_t state;
  logic [CNT_W-1:0] stepCnt;
  logic lastStep;

  assign lastStep = stepCnt == CNT_W'(QW - 1);
  assign scanning = state == ST_SCAN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      colSel <= '0;
      stepCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SCAN;
          colSel <= '0;
        end
        ST_SCAN: if (colSel == COL_W'(NX - 1)) state <= ST_PREP;
                 else colSel <= colSel + 1'b1;
        ST_PREP: begin
          stepCnt <= '0;
          if (areaZero) begin
            state <= ST_IDLE;
            done <= 1'b1;
          end else state <= ST_DIVX;
        end
        ST_DIVX: if (lastStep) state <= ST_MIDY;
                 else stepCnt <= stepCnt + 1'b1;
        ST_MIDY: begin
          state <= ST_DIVY;
          stepCnt <= '0;
        end
        ST_DIVY: if (lastStep) state <= ST_FIN;
                 else stepCnt <= stepCnt + 1'b1;
        ST_FIN: begin
          state <= ST_IDLE;
          done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl = '0;
    ctl.clearAcc = (state == ST_IDLE) && start;
    ctl.accum    = state == ST_SCAN;
    ctl.loadX    = (state == ST_PREP) && !areaZero;
    ctl.zeroOut  = (state == ST_PREP) && areaZero;
    ctl.step     = (state == ST_DIVX) || (state == ST_DIVY);
    ctl.keepX    = state == ST_MIDY;
    ctl.loadY    = state == ST_MIDY;
    ctl.publish  = state == ST_FIN;
  end
endmodule

// File: rtl/centroid_datapath.sv
module centroid_datapath
  import centroid_pkg::*;
#(
  parameter int NX = 640,
  parameter int NY = 480,
  parameter int FRAC_BITS = 6,
  localparam int COL_W  = $clog2(NX),
  localparam int ROW_W  = $clog2(NY),
  localparam int CA_W   = $clog2(NY + 1),
  localparam int CX_W   = COL_W + CA_W,
  localparam int CY_W   = ROW_W + CA_W,
  localparam int AREA_W = $clog2(NX * NY + 1),
  localparam int SX_W   = COL_W + AREA_W,
  localparam int SY_W   = ROW_W + AREA_W,
  localparam int QX_W   = COL_W + FRAC_BITS,
  localparam int QY_W   = ROW_W + FRAC_BITS,
  localparam int QW     = (QX_W > QY_W) ? QX_W : QY_W,
  localparam int DV_W   = AREA_W + QW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [CA_W-1:0]   colArea,
  input  logic [CX_W-1:0]   colSumX,
  input  logic [CY_W-1:0]   colSumY,
  output logic              areaZero,
  output logic [AREA_W-1:0] area,
  output logic [QX_W-1:0]   centX,
  output logic [QY_W-1:0]   centY,
  output logic              noPupil
);
  logic [AREA_W-1:0] accArea;
  logic [SX_W-1:0]   accX;
  logic [SY_W-1:0]   accY;
  logic [QW-1:0]     quoX, quotient;
  logic [DV_W-1:0]   dividend;

  assign areaZero = accArea == '0;
  assign dividend = ctl.loadX ? (DV_W'(accX) << FRAC_BITS) : (DV_W'(accY) << FRAC_BITS);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAcc) begin
      accArea <= '0;
      accX <= '0;
      accY <= '0;
    end else if (ctl.accum) begin
      accArea <= accArea + AREA_W'(colArea);
      accX <= accX + SX_W'(colSumX);
      accY <= accY + SY_W'(colSumY);
    end
  end

  centroid_divider #(.AREA_W(AREA_W), .QW(QW)) div_i (
    .clk(clk), .rstN(rstN), .load(ctl.loadX || ctl.loadY), .step(ctl.step),
    .dividend(dividend), .divisor(accArea), .quotient(quotient)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoX <= '0;
      area <= '0;
      centX <= '0;
      centY <= '0;
      noPupil <= 1'b0;
    end else begin
      if (ctl.keepX) quoX <= quotient;
      if (ctl.publish) begin
        area <= accArea;
        centX <= quoX[QX_W-1:0];
        centY <= quotient[QY_W-1:0];
        noPupil <= 1'b0;
      end else if (ctl.zeroOut) begin
        area <= '0;
        centX <= '0;
        centY <= '0;
        noPupil <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/centroid_reducer.sv
module centroid_reducer
  import centroid_pkg::*;
#(
  parameter int NX = 640,
  parameter int NY = 480,
  parameter int FRAC_BITS = 6,
  localparam int COL_W  = $clog2(NX),
  localparam int ROW_W  = $clog2(NY),
  localparam int CA_W   = $clog2(NY + 1),
  localparam int CX_W   = COL_W + CA_W,
  localparam int CY_W   = ROW_W + CA_W,
  localparam int AREA_W = $clog2(NX * NY + 1),
  localparam int QX_W   = COL_W + FRAC_BITS,
  localparam int QY_W   = ROW_W + FRAC_BITS,
  localparam int QW     = (QX_W > QY_W) ? QX_W : QY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [COL_W-1:0]  colSel,
  input  logic [CA_W-1:0]   colArea,
  input  logic [CX_W-1:0]   colSumX,
  input  logic [CY_W-1:0]   colSumY,
  output logic [AREA_W-1:0] area,
  output logic [QX_W-1:0]   centX,
  output logic [QY_W-1:0]   centY,
  output logic              noPupil,
  output logic              done
);
  ctrl_t ctl;
  logic  areaZero;
  logic  scanning;

  centroid_ctrl #(.NX(NX), .QW(QW)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .areaZero(areaZero),
    .ctl(ctl), .colSel(colSel), .scanning(scanning), .done(done)
  );

  centroid_datapath #(.NX(NX), .NY(NY), .FRAC_BITS(FRAC_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .colArea(colArea), .colSumX(colSumX), .colSumY(colSumY),
    .areaZero(areaZero), .area(area), .centX(centX), .centY(centY),
    .noPupil(noPupil)
  );
endmodule

// File: rtl/centroid_reducer_chk.sv
module centroid_reducer_chk #(
  parameter int NX = 640,
  parameter int COL_W = 10,
  parameter int AREA_W = 19,
  parameter int QX_W = 16,
  parameter int QY_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              scanning,
  input logic [COL_W-1:0]  colSel,
  input logic [AREA_W-1:0] area,
  input logic [QX_W-1:0]   centX,
  input logic [QY_W-1:0]   centY,
  input logic              noPupil,
  input logic              done
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_scan_origin_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanning) |-> colSel == '0);

  assert_scan_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && colSel != COL_W'(NX - 1)) |=> colSel == $past(colSel) + 1'b1);

  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    noPupil |-> (centX == '0 && centY == '0 && area == '0));

  assert_empty_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (done && area == '0) |-> noPupil);

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({area, centX, centY, noPupil}) |-> done);
endmodule

bind centroid_reducer centroid_reducer_chk #(
  .NX(NX), .COL_W(COL_W), .AREA_W(AREA_W), .QX_W(QX_W), .QY_W(QY_W)
) chk_i (
  .clk(clk), .rstN(rstN), .scanning(scanning), .colSel(colSel), .area(area),
  .centX(centX), .centY(centY), .noPupil(noPupil), .done(done)
);

// File: tb/centroid_reducer_tb_top.sv
module centroid_reducer_tb_top;
  localparam int NX = 8;
  localparam int NY = 6;
  localparam int FB = 4;
  localparam int COL_W = $clog2(NX);
  localparam int ROW_W = $clog2(NY);
  localparam int CA_W = $clog2(NY + 1);
  localparam int CX_W = COL_W + CA_W;
  localparam int CY_W = ROW_W + CA_W;
  localparam int AREA_W = $clog2(NX * NY + 1);
  localparam int QX_W = COL_W + FB;
  localparam int QY_W = ROW_W + FB;
  localparam int QW = (QX_W > QY_W) ? QX_W : QY_W;
  localparam int LAT_FULL = NX + 3 + 2 * QW;
  localparam int LAT_EMPTY = NX + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [COL_W-1:0] colSel;
  logic [CA_W-1:0] colArea;
  logic [CX_W-1:0] colSumX;
  logic [CY_W-1:0] colSumY;
  logic [AREA_W-1:0] area;
  logic [QX_W-1:0] centX;
  logic [QY_W-1:0] centY;
  logic noPupil, done;
  logic [NX-1:0] mask [NY];

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  centroid_reducer #(.NX(NX), .NY(NY), .FRAC_BITS(FB)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .colSel(colSel),
    .colArea(colArea), .colSumX(colSumX), .colSumY(colSumY),
    .area(area), .centX(centX), .centY(centY), .noPupil(noPupil), .done(done)
  );

  // Column array model: values of the column named by colSel.
  always_comb begin
    int cnt, sy;
    cnt = 0;
    sy = 0;
    for (int y = 0; y < NY; y++)
      if (mask[y][colSel]) begin
        cnt++;
        sy += y;
      end
    colArea = CA_W'(cnt);
    colSumY = CY_W'(sy);
    colSumX = CX_W'(cnt * int'(colSel));
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic runFrame(input bit midStart, input bit holdTest);
    longint ea, esx, esy, ecx, ecy;
    int cycles;
    bit orderOk;
    ea = 0; esx = 0; esy = 0;
    for (int y = 0; y < NY; y++)
      for (int x = 0; x < NX; x++)
        if (mask[y][x]) begin
          ea++;
          esx += x;
          esy += y;
        end
    ecx = (ea == 0) ? 0 : (esx << FB) / ea;
    ecy = (ea == 0) ? 0 : (esy << FB) / ea;
    @(negedge clk) start = 1'b1;
    @(posedge clk) #1;
    cycles = 0;
    orderOk = (colSel == '0);
    while (!done && cycles < 100) begin
      @(negedge clk) start = midStart && (cycles == 3);
      @(posedge clk) #1;
      cycles++;
      if (cycles < NX && int'(colSel) != cycles) orderOk = 0;
    end
    @(negedge clk) start = 1'b0;
    check(orderOk, "R1 column order", longint'(colSel), NX - 1);
    check(cycles == ((ea == 0) ? LAT_EMPTY : LAT_FULL), midStart ? "R8 latency with mid-frame start" : "R6 done latency",
          cycles, (ea == 0) ? LAT_EMPTY : LAT_FULL);
    check(longint'(area) == ea, "R2 area", longint'(area), ea);
    check(longint'(centX) == ecx, "R3 centX", longint'(centX), ecx);
    check(longint'(centY) == ecy, "R4 centY", longint'(centY), ecy);
    check(noPupil == (ea == 0), "R5 noPupil", longint'(noPupil), longint'(ea == 0));
    @(posedge clk) #1;
    check(!done, "R6 done single cycle", longint'(done), 0);
    if (holdTest) begin
      for (int y = 0; y < NY; y++) mask[y] = ~mask[y];
      repeat (5) @(posedge clk);
      #1;
      check(longint'(area) == ea && longint'(centX) == ecx && longint'(centY) == ecy,
            "R7 hold after done", longint'(area), ea);
    end
  endtask

  task automatic setMask(input int density);
    for (int y = 0; y < NY; y++)
      for (int x = 0; x < NX; x++)
        mask[y][x] = ($urandom % 100) < density;
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int y = 0; y < NY; y++) mask[y] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(!done && !noPupil && area == '0 && centX == '0 && centY == '0 && colSel == '0,
          "R9 reset state", longint'(area), 0);
    @(negedge clk) rstN = 1'b1;
    runFrame(0, 1);                                   // empty frame, R5
    for (int y = 0; y < NY; y++) mask[y] = '1;
    runFrame(0, 1);                                   // full frame
    for (int y = 0; y < NY; y++)                      // every single-pixel position
      for (int x = 0; x < NX; x++) begin
        for (int k = 0; k < NY; k++) mask[k] = '0;
        mask[y][x] = 1'b1;
        runFrame(0, 0);
      end
    for (int i = 0; i < 40; i++) begin                // random masks, R3 R4
      setMask(5 + (i * 23) % 90);
      runFrame(i % 5 == 0, i % 7 == 0);
    end
    for (int y = 0; y < NY; y++) mask[y] = '0;
    runFrame(1, 0);                                   // R8 on empty frame
    summary();
  end
endmodule